// File: doc/BRIEF.md
# Epoch-Paced Write Throttle

This block paces page writes into a storage device so that the device's writable budget lasts until its target lifetime and is used up close to that point. Time is divided into epochs. The host marks each epoch boundary with a one-cycle tick, and an epoch should span one period of the workload's cycle. The block counts the pages acknowledged in each epoch. At each tick it removes the written bytes from the remaining budget and takes one epoch off the remaining count. The demand of the epoch just ended is used as the prediction for the next epoch.

One cycle after the tick, the block compares that prediction with the share of the budget left for each remaining epoch, which is the remaining bytes divided by the remaining epochs. If demand is above that share, the per-write delay goes up by a fixed step. If demand is below it, the delay goes down by the same step. If the two are equal, the delay does not change. The delay is held within zero and a maximum. When no epochs remain, the delay goes straight to the maximum.

Each page write is held for the same delay. A requester raises `wr_req` and keeps it high until `wr_ack` pulses. Writes are therefore served one at a time, in order. Every write in an epoch sees the same response time, instead of running free and then meeting a hard bandwidth cap.

Top module: `wear_pacer`

## Requirements
- R1: While `rst_n` is low, the remaining budget takes `cfg_budget` and the remaining epoch count takes `cfg_epochs`. After reset, `cur_delay` is 0 and `wr_ack` and `wr_stall` are low.
- R2: A write request first seen at a rising edge while the block is idle is acknowledged by a one-cycle `wr_ack` that becomes visible D+1 edges later, where D is `cur_delay` at that first edge. `wr_stall` is high whenever `wr_req` is high and `wr_ack` is low.
- R3: Writes are served one at a time in arrival order. If `wr_req` stays high across back-to-back writes, consecutive acknowledges are D+2 cycles apart.
- R4: At a rising edge with `epoch_tick` high, the budget drops by (pages acknowledged in the epoch) × PAGE_BYTES, saturating at 0. At the same edge the epoch count drops by one, saturating at 0. Between ticks, neither value changes.
- R5: The predicted demand equals the bytes acknowledged in the epoch that just ended, and only those. An acknowledge at the tick edge counts toward the ending epoch. The capacity is the budget after the tick divided by the epoch count after the tick. `cur_delay` takes its new value at the edge that follows the tick edge.
- R6: If predicted demand is greater than capacity, the delay rises by DELAY_STEP (default 4), clamped at DELAY_MAX (default 200).
- R7: If predicted demand is less than capacity, the delay falls by DELAY_STEP, clamped at 0.
- R8: If predicted demand equals capacity, the delay is unchanged.
- R9: If the epoch count is 0 after a tick, the delay becomes DELAY_MAX, whatever the demand.
- R10: `cur_delay` never exceeds DELAY_MAX and changes only at the edge that follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| cfg_budget | input | 32 | Initial writable budget in bytes, sampled during reset |
| cfg_epochs | input | 16 | Initial number of epochs until the target lifetime, sampled during reset |
| epoch_tick | input | 1 | One-cycle pulse marking the end of an epoch |
| wr_req | input | 1 | Page write request, held until acknowledged |
| wr_ack | output | 1 | One-cycle acknowledge ending the current write's delay |
| wr_stall | output | 1 | High while a requested write is being held |
| cur_delay | output | 8 | Per-write delay in cycles currently in force |
| budget_left | output | 32 | Remaining writable bytes |
| epochs_left | output | 16 | Remaining epochs |

## Verification
Some properties are checked on every cycle by assertions. The delay stays at or below its maximum and moves only on the cycle after a tick. An exhausted epoch count forces the maximum. The budget and epoch count hold between ticks and never grow. The prediction holds between ticks, and an acknowledge lasts a single cycle. The bench scenarios cover the rest: exact write latency and back-to-back spacing at different delays, saturating budget arithmetic, and the choice among increase, decrease and hold when demand is above, below or equal to capacity. Only the scenarios can show that the prediction uses the last epoch alone and that capacity uses the budget after the tick.

// File: rtl/wp_pkg.sv
// Shared types for the epoch-paced write throttle.
// Assumes: nothing beyond standard SystemVerilog.
package wp_pkg;

    // Result of comparing predicted demand with epoch capacity
    typedef enum logic [1:0] {
        DEM_BELOW = 2'd0,
        DEM_MATCH = 2'd1,
        DEM_ABOVE = 2'd2
    } demand_cmp_t;

    // Write gate states
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_t;

endpackage

// File: rtl/wp_epoch_meter.sv
// Counts acknowledged page writes within the current epoch.
// Provides the byte total of the ending epoch (combinational, for the
// budget) and registers it as the next epoch's predicted demand.
// Assumes: epoch_tick is a single-cycle pulse; an acknowledge in the tick
// cycle belongs to the ending epoch.
module wp_epoch_meter #(
    parameter int unsigned PCNT_W     = 16,
    parameter int unsigned WIDE_W     = 48,
    parameter int unsigned PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              epoch_tick,
    input  logic              page_done,
    output logic [WIDE_W-1:0] epoch_bytes,
    output logic [WIDE_W-1:0] pred_bytes
);
    localparam logic [WIDE_W-1:0] PB = WIDE_W'(PAGE_BYTES);

    logic [PCNT_W-1:0] pages_q;
    logic [PCNT_W-1:0] pages_now;
    logic [WIDE_W-1:0] pred_q;

    // Page count including an acknowledge in this cycle, saturating
    always_comb begin
        if (page_done && (pages_q != {PCNT_W{1'b1}}))
            pages_now = pages_q + PCNT_W'(1);
        else
            pages_now = pages_q;
    end

    assign epoch_bytes = WIDE_W'(pages_now) * PB;

    // Per-epoch page counter, cleared at each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            pages_q <= '0;
        else if (epoch_tick)
            pages_q <= '0;
        else
            pages_q <= pages_now;
    end

    // Prediction register: demand of the epoch just ended
    always_ff @(posedge clk) begin
        if (!rst_n)
            pred_q <= '0;
        else if (epoch_tick)
            pred_q <= epoch_bytes;
    end

    assign pred_bytes = pred_q;

    // R5
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_tick |=> $stable(pred_q));

endmodule

// File: rtl/wp_budget_tracker.sv
// Keeps the remaining writable budget and remaining epoch count and
// derives the per-epoch capacity from them.
// Assumes: configuration is stable while rst_n is low; epoch_bytes is
// the byte total of the ending epoch, valid in the tick cycle.
module wp_budget_tracker #(
    parameter int unsigned BUDGET_W = 32,
    parameter int unsigned EPOCH_W  = 16,
    parameter int unsigned WIDE_W   = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUDGET_W-1:0] cfg_budget,
    input  logic [EPOCH_W-1:0]  cfg_epochs,
    input  logic                epoch_tick,
    input  logic [WIDE_W-1:0]   epoch_bytes,
    output logic [BUDGET_W-1:0] budget_left,
    output logic [EPOCH_W-1:0]  epochs_left,
    output logic [BUDGET_W-1:0] capacity
);
    logic [BUDGET_W-1:0] budget_q;
    logic [EPOCH_W-1:0]  epochs_q;

    // Budget: load at reset, saturating subtract at each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            budget_q <= cfg_budget;
        else if (epoch_tick) begin
            if (epoch_bytes >= WIDE_W'(budget_q))
                budget_q <= '0;
            else
                budget_q <= budget_q - BUDGET_W'(epoch_bytes);
        end
    end

    // Epoch count: load at reset, saturating decrement at each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            epochs_q <= cfg_epochs;
        else if (epoch_tick && (epochs_q != '0))
            epochs_q <= epochs_q - EPOCH_W'(1);
    end

    // Capacity share per remaining epoch (zero when none remain)
    always_comb begin
        if (epochs_q == '0)
            capacity = '0;
        else
            capacity = budget_q / BUDGET_W'(epochs_q);
    end

    assign budget_left = budget_q;
    assign epochs_left = epochs_q;

    // R4
    budget_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !epoch_tick |=> $stable(budget_q) && $stable(epochs_q));

    // R4
    budget_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        epoch_tick |=> (budget_q <= $past(budget_q)) && (epochs_q <= $past(epochs_q)));

endmodule

// File: rtl/wp_delay_adapter.sv
// Adjusts the per-write delay once per epoch, one cycle after the tick,
// by comparing predicted demand with the capacity share.
// Assumes: budget, epoch count and prediction have been updated at the
// tick edge, so they are current in the cycle after it.
module wp_delay_adapter
    import wp_pkg::*;
#(
    parameter int unsigned BUDGET_W   = 32,
    parameter int unsigned EPOCH_W    = 16,
    parameter int unsigned WIDE_W     = 48,
    parameter int unsigned DELAY_W    = 8,
    parameter int unsigned DELAY_MAX  = 200,
    parameter int unsigned DELAY_STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                epoch_tick,
    input  logic [WIDE_W-1:0]   pred_bytes,
    input  logic [BUDGET_W-1:0] capacity,
    input  logic [EPOCH_W-1:0]  epochs_left,
    output logic [DELAY_W-1:0]  delay
);
    localparam logic [DELAY_W:0]   MAX_W  = (DELAY_W+1)'(DELAY_MAX);
    localparam logic [DELAY_W:0]   STEP_W = (DELAY_W+1)'(DELAY_STEP);
    localparam logic [DELAY_W-1:0] MAX_D  = DELAY_W'(DELAY_MAX);
    localparam logic [DELAY_W-1:0] STEP_D = DELAY_W'(DELAY_STEP);

    logic               upd_q;
    logic [DELAY_W-1:0] delay_q;
    logic [DELAY_W-1:0] delay_up;
    logic [DELAY_W-1:0] delay_dn;
    logic [DELAY_W:0]   up_sum;
    demand_cmp_t        cmp;

    // Update strobe: one cycle after the epoch tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else
            upd_q <= epoch_tick;
    end

    // Classify predicted demand against capacity
    always_comb begin
        if (pred_bytes > WIDE_W'(capacity))
            cmp = DEM_ABOVE;
        else if (pred_bytes < WIDE_W'(capacity))
            cmp = DEM_BELOW;
        else
            cmp = DEM_MATCH;
    end

    // Clamped step-up and step-down candidates
    always_comb begin
        up_sum   = {1'b0, delay_q} + STEP_W;
        delay_up = (up_sum > MAX_W) ? MAX_D : up_sum[DELAY_W-1:0];
        delay_dn = (delay_q >= STEP_D) ? (delay_q - STEP_D) : '0;
    end

    // Delay register: changed only on the update strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            delay_q <= '0;
        else if (upd_q) begin
            if (epochs_left == '0)
                delay_q <= MAX_D;
            else begin
                case (cmp)
                    DEM_ABOVE: delay_q <= delay_up;
                    DEM_BELOW: delay_q <= delay_dn;
                    default:   delay_q <= delay_q;
                endcase
            end
        end
    end

    assign delay = delay_q;

    // R10
    delay_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay_q <= MAX_D);

    // R10
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> $stable(delay_q));

    // R9
    exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && (epochs_left == '0)) |=> (delay_q == MAX_D));

endmodule

// File: rtl/wp_write_gate.sv
// Holds each page write for the delay in force when it is accepted,
// then acknowledges it with a one-cycle pulse.
// Assumes: the requester holds wr_req high until wr_ack; one write is
// in service at a time, so later writes wait in order.
module wp_write_gate
    import wp_pkg::*;
#(
    parameter int unsigned DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [DELAY_W-1:0] delay,
    output logic               wr_ack,
    output logic               wr_stall
);
    gate_state_t        st_q;
    logic [DELAY_W-1:0] cnt_q;

    // Accept a request, count down its delay, release when done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= GATE_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                GATE_IDLE: begin
                    if (wr_req) begin
                        st_q  <= GATE_HOLD;
                        cnt_q <= delay;
                    end
                end
                default: begin
                    if (cnt_q == '0)
                        st_q <= GATE_IDLE;
                    else
                        cnt_q <= cnt_q - DELAY_W'(1);
                end
            endcase
        end
    end

    assign wr_ack   = (st_q == GATE_HOLD) && (cnt_q == '0);
    assign wr_stall = wr_req && !wr_ack;

    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);

endmodule

// File: rtl/wear_pacer.sv
// Epoch-paced write throttle: meters per-epoch writes, tracks the
// remaining budget and epochs, adapts a per-write delay each epoch and
// holds every page write for that delay.
// Assumes: cfg_* stable during reset; epoch_tick single-cycle pulses;
// wr_req held until wr_ack.
module wear_pacer #(
    parameter int unsigned BUDGET_W   = 32,
    parameter int unsigned EPOCH_W    = 16,
    parameter int unsigned PCNT_W     = 16,
    parameter int unsigned PAGE_BYTES = 4096,
    parameter int unsigned DELAY_W    = 8,
    parameter int unsigned DELAY_MAX  = 200,
    parameter int unsigned DELAY_STEP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUDGET_W-1:0] cfg_budget,
    input  logic [EPOCH_W-1:0]  cfg_epochs,
    input  logic                epoch_tick,
    input  logic                wr_req,
    output logic                wr_ack,
    output logic                wr_stall,
    output logic [DELAY_W-1:0]  cur_delay,
    output logic [BUDGET_W-1:0] budget_left,
    output logic [EPOCH_W-1:0]  epochs_left
);
    localparam int unsigned WIDE_W = BUDGET_W + PCNT_W;

    logic [WIDE_W-1:0]   epoch_bytes;
    logic [WIDE_W-1:0]   pred_bytes;
    logic [BUDGET_W-1:0] capacity;

    wp_epoch_meter #(
        .PCNT_W(PCNT_W), .WIDE_W(WIDE_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick),
        .page_done(wr_ack), .epoch_bytes(epoch_bytes), .pred_bytes(pred_bytes)
    );

    wp_budget_tracker #(
        .BUDGET_W(BUDGET_W), .EPOCH_W(EPOCH_W), .WIDE_W(WIDE_W)
    ) u_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_budget(cfg_budget), .cfg_epochs(cfg_epochs),
        .epoch_tick(epoch_tick), .epoch_bytes(epoch_bytes),
        .budget_left(budget_left), .epochs_left(epochs_left), .capacity(capacity)
    );

    wp_delay_adapter #(
        .BUDGET_W(BUDGET_W), .EPOCH_W(EPOCH_W), .WIDE_W(WIDE_W),
        .DELAY_W(DELAY_W), .DELAY_MAX(DELAY_MAX), .DELAY_STEP(DELAY_STEP)
    ) u_adapter (
        .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick),
        .pred_bytes(pred_bytes), .capacity(capacity),
        .epochs_left(epochs_left), .delay(cur_delay)
    );

    wp_write_gate #(
        .DELAY_W(DELAY_W)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .delay(cur_delay),
        .wr_ack(wr_ack), .wr_stall(wr_stall)
    );

endmodule

// File: tb/wear_pacer_tb.sv
// Directed bench for wear_pacer: one task per scenario, each checking
// its own results against values worked out from the requirements.
module wear_pacer_tb;
    localparam longint PG = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_budget = '0;
    logic [15:0] cfg_epochs = '0;
    logic        epoch_tick = 1'b0;
    logic        wr_req = 1'b0;
    logic        wr_ack;
    logic        wr_stall;
    logic [7:0]  cur_delay;
    logic [31:0] budget_left;
    logic [15:0] epochs_left;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wear_pacer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_budget(cfg_budget), .cfg_epochs(cfg_epochs),
        .epoch_tick(epoch_tick), .wr_req(wr_req), .wr_ack(wr_ack), .wr_stall(wr_stall),
        .cur_delay(cur_delay), .budget_left(budget_left), .epochs_left(epochs_left)
    );

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic do_reset(input longint budget, input int epochs);
        @(negedge clk);
        cfg_budget = 32'(budget);
        cfg_epochs = 16'(epochs);
        rst_n = 1'b0;
        wr_req = 1'b0;
        epoch_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One page write; returns edges from acceptance to visible acknowledge
    task automatic write_page(output int lat, output bit stalled);
        int n = 0;
        wr_req = 1'b1;
        stalled = 1'b0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) stalled = wr_stall;
            if (wr_ack) break;
        end
        wr_req = 1'b0;
        lat = n;
        @(negedge clk);
    endtask

    task automatic write_pages(input int cnt);
        int lat;
        bit st;
        for (int i = 0; i < cnt; i++) write_page(lat, st);
    endtask

    // Tick pulse, then wait for the delay update edge
    task automatic tick_epoch();
        epoch_tick = 1'b1;
        @(negedge clk);
        epoch_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(20 * PG, 3);
        chk("R1 delay after reset", cur_delay, 0);
        chk("R1 budget loaded", budget_left, 20 * PG);
        chk("R1 epochs loaded", epochs_left, 3);
        chk("R1 ack low", wr_ack, 0);
        chk("R1 stall low", wr_stall, 0);
    endtask

    task automatic t_equal_and_exhaust();
        int lat;
        int gap;
        bit st;
        do_reset(20 * PG, 3);
        write_page(lat, st);
        chk("R2 latency at delay 0", lat, 1);
        write_pages(9);
        tick_epoch();
        chk("R4 budget after 10 pages", budget_left, 10 * PG);
        chk("R4 epochs decremented", epochs_left, 2);
        chk("R6 demand above raises delay", cur_delay, 4);
        write_page(lat, st);
        chk("R2 latency at delay 4", lat, 5);
        chk("R2 stall while held", st, 1);
        write_pages(4);
        tick_epoch();
        chk("R8 demand equals capacity holds delay", cur_delay, 4);
        chk("R4 budget 5 pages", budget_left, 5 * PG);
        // back-to-back with request held
        wr_req = 1'b1;
        do @(negedge clk); while (!wr_ack);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!wr_ack);
        wr_req = 1'b0;
        @(negedge clk);
        chk("R3 back-to-back ack spacing", gap, 6);
        write_pages(5);
        tick_epoch();
        chk("R4 budget saturates at zero", budget_left, 0);
        chk("R4 epochs reach zero", epochs_left, 0);
        chk("R9 no epochs forces max", cur_delay, 200);
        tick_epoch();
        chk("R4 epochs stay zero", epochs_left, 0);
        chk("R9 max held when exhausted", cur_delay, 200);
    endtask

    task automatic t_decrease_clamp();
        do_reset(30 * PG, 4);
        write_pages(10);
        tick_epoch();
        chk("R6 raise from zero", cur_delay, 4);
        write_pages(5);
        chk("R10 delay stable within epoch", cur_delay, 4);
        tick_epoch();
        chk("R4 budget 15 pages", budget_left, 15 * PG);
        chk("R7 demand below lowers delay", cur_delay, 0);
        tick_epoch();
        chk("R7 lower clamps at zero", cur_delay, 0);
        chk("R4 idle epoch keeps budget", budget_left, 15 * PG);
    endtask

    task automatic t_last_epoch_only();
        do_reset(100 * PG, 10);
        write_pages(12);
        tick_epoch();
        chk("R5 12 pages above 88/9 share", cur_delay, 4);
        write_pages(9);
        tick_epoch();
        chk("R5 only last epoch predicts (9 below 79/8)", cur_delay, 0);
        chk("R4 budget 79 pages", budget_left, 79 * PG);
    endtask

    initial begin
        t_reset_state();
        t_equal_and_exhaust();
        t_decrease_clamp();
        t_last_epoch_only();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule